// File: doc/BRIEF.md
# Flash Mailbox Command Controller

This block sits on the special-function-register bus of an 8-bit microcontroller. It lets running code program and erase a two-block on-chip flash. Software loads a 16-bit flash address and a data byte into mailbox registers, then writes a command byte. The controller decodes that byte. If in-application commands are enabled it starts the operation, and it reports progress through two busy flags in a read-only status register. A command byte can also ask for a completion interrupt. In that case the controller takes over the INT1 request line until the next command write.

The flash array is modelled inside the block as a behavioural byte memory. The main block starts at 0000h and uses 128-byte sectors. The small upper block starts at F000h and uses 64-byte sectors. Erase and program latencies are parameters counted in clock cycles, and each clock is one machine cycle. A burst program runs in two phases. First the byte itself is written. Then a recovery tail follows, during which only another burst program is accepted.

Top module: `flash_mbox_ctrl`

## Requirements
- R1: After reset, the following hold.
  - The command, address-low, address-high and data registers read 00h.
  - The configuration register reads its upper six bits as 0 and its two low bits as `remap_init`.
  - Status reads only the lock bits.
  - Every flash byte holds FFh.
  - `int1_n` follows `ext_int1_n`.
- R2: The registers sit at these SFR addresses: B1h configuration, B2h command, B3h address low, B4h address high, B5h data, B6h status. Status is read-only, and a write to it changes nothing. Status bits 7:5 are `lock_bits`, bit 1 is BUSY, bit 0 is Flash_busy, and bits 4:2 read 0.
- R3: The command register holds the interrupt-enable flag in bit 7 and the code in bits 6:0. The codes are 01h chip erase, 06h burst program, 0Bh sector erase, 0Ch byte verify, 0Dh block erase and 0Eh byte program. Any other code starts nothing and leaves the flash unchanged.
- R4: While configuration bit 6 is 0, no command starts, and Flash_busy stays 0.
- R5: Byte program holds both BUSY and Flash_busy at 1 for exactly PROG_LAT cycles after the command write. The new byte value is the old value ANDed with the data register.
- R6: Each erase holds Flash_busy for exactly ERASE_LAT cycles and sets the selected bytes to FFh.
  - Sector erase clears the addressed 128-byte main sector, or the addressed 64-byte upper sector.
  - Block erase clears the upper block when address bits 15:12 are Fh, and the main block otherwise.
  - Chip erase clears both blocks.
- R7: Byte verify holds Flash_busy for one cycle and then loads the data register with the addressed byte. An address outside both blocks reads FFh. Byte verify never raises the completion interrupt.
- R8: Burst program works in two phases.
  - BUSY is held for PROG_LAT cycles, and then Flash_busy alone is held for TAIL_LAT more cycles.
  - A burst program written during that tail restarts the byte phase.
  - Any other command written during the tail is ignored.
- R9: A command write while Flash_busy is 1, outside the burst tail case, is ignored. It changes neither the command register nor the running operation.
- R10: When the stored command has bit 7 set, `int1_n` goes low at the edge where that command's Flash_busy falls, and stays low until the next accepted command write. While bit 7 is set, `ext_int1_n` is ignored. When bit 7 is clear, `int1_n` equals `ext_int1_n`.
- R11: Configuration bit 7 drives `upper_vis` and bits 1:0 drive `map_en`. Configuration bits 5:2 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one machine cycle per period |
| rst | input | 1 | Synchronous active-high reset |
| sfr_we | input | 1 | SFR write strobe |
| sfr_addr | input | 8 | SFR address for reads and writes |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | Read data of the addressed mailbox register, 00h for other addresses |
| remap_init | input | 2 | Reset value for configuration bits 1:0 |
| lock_bits | input | 3 | Security lock state, reported in status bits 7:5 |
| ext_int1_n | input | 1 | External INT1 request, active low |
| int1_n | output | 1 | INT1 request towards the interrupt controller, active low |
| upper_vis | output | 1 | Upper block visible to code fetch |
| map_en | output | 2 | Remap selection from configuration bits 1:0 |

## Verification
The bound checker watches several rules on every cycle:
- BUSY never rises without Flash_busy.
- Flash_busy rises only after a command write made while commands were enabled.
- The block stays idle while commands are disabled.
- A routed completion interrupt falls only together with Flash_busy.

Only the directed scenarios can show the rest:
- Exact latencies and the two-phase burst timing.
- The AND semantics of programming.
- The 128-byte and 64-byte sector boundaries, and block and chip scope.
- Rejection of reserved, disabled and mid-operation commands, shown through memory contents read back by byte verify.

// File: rtl/flash_mbox_pkg.sv
package flash_mbox_pkg;

    localparam logic [7:0] SFR_CFG = 8'hB1;
    localparam logic [7:0] SFR_CMD = 8'hB2;
    localparam logic [7:0] SFR_ADL = 8'hB3;
    localparam logic [7:0] SFR_ADH = 8'hB4;
    localparam logic [7:0] SFR_DAT = 8'hB5;
    localparam logic [7:0] SFR_STS = 8'hB6;

    localparam int MAIN_SEC_SHIFT  = 7;
    localparam int UPPER_SEC_SHIFT = 6;
    localparam logic [3:0] UPPER_NIB = 4'hF;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_CHIP_ERASE,
        OP_BURST_PROG,
        OP_SECT_ERASE,
        OP_VERIFY,
        OP_BLOCK_ERASE,
        OP_BYTE_PROG
    } fop_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_RUN,
        PH_TAIL
    } phase_e;

    typedef struct packed {
        logic       vis;
        logic       iap_en;
        logic [1:0] map_en;
    } cfg_t;

    typedef struct packed {
        logic       fie;
        logic [6:0] code;
    } cmd_t;

    function automatic fop_e decode_cmd(input logic [6:0] code);
        case (code)
            7'h01:   return OP_CHIP_ERASE;
            7'h06:   return OP_BURST_PROG;
            7'h0B:   return OP_SECT_ERASE;
            7'h0C:   return OP_VERIFY;
            7'h0D:   return OP_BLOCK_ERASE;
            7'h0E:   return OP_BYTE_PROG;
            default: return OP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/fmb_regs.sv
module fmb_regs
    import flash_mbox_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [7:0]  addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    input  logic [1:0]  remap_init,
    input  logic [2:0]  lock_bits,
    input  logic        busy,
    input  logic        fbusy,
    input  logic        verify_load,
    input  logic [7:0]  verify_byte,
    output cfg_t        cfg_q,
    output cmd_t        cmd_q,
    output logic [15:0] flash_addr,
    output logic [7:0]  flash_data,
    output logic        cmd_take,
    output logic        start,
    output fop_e        start_op
);

    logic [7:0] adl_q, adh_q, dat_q;
    logic       in_tail;
    logic       cmd_hit;
    fop_e       wr_op;

    assign in_tail  = fbusy && !busy;
    assign cmd_hit  = we && (addr == SFR_CMD);
    assign wr_op    = decode_cmd(wdata[6:0]);
    assign cmd_take = cmd_hit && (!fbusy || (in_tail && wr_op == OP_BURST_PROG));
    assign start    = cmd_take && cfg_q.iap_en && (wr_op != OP_NONE);
    assign start_op = wr_op;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{vis: 1'b0, iap_en: 1'b0, map_en: remap_init};
            cmd_q <= '0;
            adl_q <= '0;
            adh_q <= '0;
            dat_q <= '0;
        end else begin
            if (we && addr == SFR_CFG)
                cfg_q <= '{vis: wdata[7], iap_en: wdata[6], map_en: wdata[1:0]};
            if (cmd_take)
                cmd_q <= '{fie: wdata[7], code: wdata[6:0]};
            if (we && addr == SFR_ADL)
                adl_q <= wdata;
            if (we && addr == SFR_ADH)
                adh_q <= wdata;
            if (verify_load)
                dat_q <= verify_byte;
            else if (we && addr == SFR_DAT)
                dat_q <= wdata;
        end
    end

    always_comb begin
        case (addr)
            SFR_CFG: rdata = {cfg_q.vis, cfg_q.iap_en, 4'b0000, cfg_q.map_en};
            SFR_CMD: rdata = {cmd_q.fie, cmd_q.code};
            SFR_ADL: rdata = adl_q;
            SFR_ADH: rdata = adh_q;
            SFR_DAT: rdata = dat_q;
            SFR_STS: rdata = {lock_bits, 3'b000, busy, fbusy};
            default: rdata = 8'h00;
        endcase
    end

    assign flash_addr = {adh_q, adl_q};
    assign flash_data = dat_q;

endmodule

// File: rtl/fmb_seq.sv
module fmb_seq
    import flash_mbox_pkg::*;
#(
    parameter int PROG_LAT  = 6,
    parameter int ERASE_LAT = 20,
    parameter int TAIL_LAT  = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  fop_e start_op,
    output logic busy,
    output logic fbusy,
    output logic exec,
    output fop_e exec_op,
    output logic done
);

    localparam int MAX_PE = (ERASE_LAT > PROG_LAT) ? ERASE_LAT : PROG_LAT;
    localparam int MAX_L  = (MAX_PE > TAIL_LAT) ? MAX_PE : TAIL_LAT;
    localparam int CW     = $clog2(MAX_L + 1);

    phase_e        ph_q;
    fop_e          op_q;
    logic [CW-1:0] cnt_q;
    logic          last;

    function automatic logic [CW-1:0] op_latency(input fop_e op);
        case (op)
            OP_VERIFY:                   return CW'(1);
            OP_BYTE_PROG, OP_BURST_PROG: return CW'(PROG_LAT);
            default:                     return CW'(ERASE_LAT);
        endcase
    endfunction

    assign last    = (cnt_q == CW'(1));
    assign busy    = (ph_q == PH_RUN);
    assign fbusy   = (ph_q != PH_IDLE);
    assign exec    = (ph_q == PH_RUN) && last;
    assign exec_op = op_q;
    assign done    = ((ph_q == PH_RUN) && last && op_q != OP_BURST_PROG && op_q != OP_VERIFY)
                   || ((ph_q == PH_TAIL) && last && !start);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            op_q  <= OP_NONE;
            cnt_q <= '0;
        end else begin
            case (ph_q)
                PH_IDLE: begin
                    if (start) begin
                        ph_q  <= PH_RUN;
                        op_q  <= start_op;
                        cnt_q <= op_latency(start_op);
                    end
                end
                PH_RUN: begin
                    if (last) begin
                        if (op_q == OP_BURST_PROG) begin
                            ph_q  <= PH_TAIL;
                            cnt_q <= CW'(TAIL_LAT);
                        end else begin
                            ph_q <= PH_IDLE;
                        end
                    end else begin
                        cnt_q <= cnt_q - CW'(1);
                    end
                end
                PH_TAIL: begin
                    if (start) begin
                        ph_q  <= PH_RUN;
                        op_q  <= start_op;
                        cnt_q <= CW'(PROG_LAT);
                    end else if (last) begin
                        ph_q <= PH_IDLE;
                    end else begin
                        cnt_q <= cnt_q - CW'(1);
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fmb_array.sv
module fmb_array
    import flash_mbox_pkg::*;
#(
    parameter int MAIN_BYTES  = 512,
    parameter int UPPER_BYTES = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        exec,
    input  fop_e        op,
    input  logic [15:0] addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rd_byte
);

    localparam int N  = MAIN_BYTES + UPPER_BYTES;
    localparam int IW = $clog2(N);

    logic [31:0] a32, u32, idx32;
    logic        up_sel, up_hit, main_hit;
    logic [7:0]  cells [N];

    assign a32      = {16'h0000, addr};
    assign u32      = {20'h00000, addr[11:0]};
    assign up_sel   = (addr[15:12] == UPPER_NIB);
    assign up_hit   = up_sel && (u32 < 32'(UPPER_BYTES));
    assign main_hit = (a32 < 32'(MAIN_BYTES));
    assign idx32    = up_hit ? (u32 + 32'(MAIN_BYTES)) : a32;
    assign rd_byte  = (up_hit || main_hit) ? cells[idx32[IW-1:0]] : 8'hFF;

    for (genvar i = 0; i < N; i++) begin : g_cell
        localparam bit          IS_UP = (i >= MAIN_BYTES);
        localparam logic [31:0] OFF   = IS_UP ? 32'(i - MAIN_BYTES) : 32'(i);
        logic [7:0] q;
        logic       in_blk, sec_hit, byte_hit;

        if (IS_UP) begin : g_up
            assign in_blk   = up_sel;
            assign sec_hit  = up_hit && ((u32 >> UPPER_SEC_SHIFT) == (OFF >> UPPER_SEC_SHIFT));
            assign byte_hit = up_hit && (u32 == OFF);
        end else begin : g_main
            assign in_blk   = !up_sel;
            assign sec_hit  = main_hit && ((a32 >> MAIN_SEC_SHIFT) == (OFF >> MAIN_SEC_SHIFT));
            assign byte_hit = main_hit && (a32 == OFF);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= 8'hFF;
            end else if (exec) begin
                case (op)
                    OP_CHIP_ERASE:               q <= 8'hFF;
                    OP_BLOCK_ERASE:              if (in_blk)   q <= 8'hFF;
                    OP_SECT_ERASE:               if (sec_hit)  q <= 8'hFF;
                    OP_BYTE_PROG, OP_BURST_PROG: if (byte_hit) q <= q & wdata;
                    default: ;
                endcase
            end
        end

        assign cells[i] = q;
    end

endmodule

// File: rtl/flash_mbox_ctrl.sv
module flash_mbox_ctrl
    import flash_mbox_pkg::*;
#(
    parameter int MAIN_BYTES  = 512,
    parameter int UPPER_BYTES = 256,
    parameter int PROG_LAT    = 6,
    parameter int ERASE_LAT   = 20,
    parameter int TAIL_LAT    = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sfr_we,
    input  logic [7:0] sfr_addr,
    input  logic [7:0] sfr_wdata,
    output logic [7:0] sfr_rdata,
    input  logic [1:0] remap_init,
    input  logic [2:0] lock_bits,
    input  logic       ext_int1_n,
    output logic       int1_n,
    output logic       upper_vis,
    output logic [1:0] map_en
);

    cfg_t        cfg_q;
    cmd_t        cmd_q;
    logic [15:0] flash_addr;
    logic [7:0]  flash_data, rd_byte;
    logic        cmd_take, start, seq_busy, seq_fbusy, exec, seq_done;
    fop_e        start_op, exec_op;
    logic        done_q, iap_en, fie, verify_load;

    assign verify_load = exec && (exec_op == OP_VERIFY);
    assign iap_en      = cfg_q.iap_en;
    assign fie         = cmd_q.fie;

    fmb_regs u_regs (
        .clk(clk), .rst(rst), .we(sfr_we), .addr(sfr_addr), .wdata(sfr_wdata),
        .rdata(sfr_rdata), .remap_init(remap_init), .lock_bits(lock_bits),
        .busy(seq_busy), .fbusy(seq_fbusy), .verify_load(verify_load),
        .verify_byte(rd_byte), .cfg_q(cfg_q), .cmd_q(cmd_q),
        .flash_addr(flash_addr), .flash_data(flash_data), .cmd_take(cmd_take),
        .start(start), .start_op(start_op)
    );

    fmb_seq #(.PROG_LAT(PROG_LAT), .ERASE_LAT(ERASE_LAT), .TAIL_LAT(TAIL_LAT)) u_seq (
        .clk(clk), .rst(rst), .start(start), .start_op(start_op),
        .busy(seq_busy), .fbusy(seq_fbusy), .exec(exec), .exec_op(exec_op),
        .done(seq_done)
    );

    fmb_array #(.MAIN_BYTES(MAIN_BYTES), .UPPER_BYTES(UPPER_BYTES)) u_array (
        .clk(clk), .rst(rst), .exec(exec), .op(exec_op), .addr(flash_addr),
        .wdata(flash_data), .rd_byte(rd_byte)
    );

    always_ff @(posedge clk) begin
        if (rst)
            done_q <= 1'b0;
        else if (cmd_take)
            done_q <= 1'b0;
        else if (seq_done && fie)
            done_q <= 1'b1;
    end

    assign int1_n    = fie ? !done_q : ext_int1_n;
    assign upper_vis = cfg_q.vis;
    assign map_en    = cfg_q.map_en;

endmodule

// File: rtl/fmb_chk.sv
module fmb_chk (
    input logic       clk,
    input logic       rst,
    input logic       sfr_we,
    input logic [7:0] sfr_addr,
    input logic       busy,
    input logic       fbusy,
    input logic       iap_en,
    input logic       fie,
    input logic       int1_n
);

    p_busy_within_fbusy_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> fbusy);

    p_start_needs_write_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(fbusy) |-> $past(sfr_we && sfr_addr == 8'hB2 && iap_en));

    p_idle_when_disabled_r4: assert property (@(posedge clk) disable iff (rst)
        (!fbusy && !iap_en) |=> !fbusy);

    p_irq_at_completion_r10: assert property (@(posedge clk) disable iff (rst)
        (fie && $past(fie) && $fell(int1_n)) |-> $fell(fbusy));

endmodule

bind flash_mbox_ctrl fmb_chk u_chk (
    .clk(clk), .rst(rst), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
    .busy(seq_busy), .fbusy(seq_fbusy), .iap_en(iap_en), .fie(fie),
    .int1_n(int1_n)
);

// File: tb/sim_flash_mbox_ctrl.sv
`timescale 1ns/1ps
module sim_flash_mbox_ctrl;

    localparam int PROG  = 6;
    localparam int ERASE = 20;
    localparam int TAIL  = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sfr_we = 1'b0;
    logic [7:0] sfr_addr = 8'h00;
    logic [7:0] sfr_wdata = 8'h00;
    logic [7:0] sfr_rdata;
    logic [1:0] remap_init = 2'b10;
    logic [2:0] lock_bits = 3'b101;
    logic       ext_int1_n = 1'b1;
    logic       int1_n, upper_vis;
    logic [1:0] map_en;

    int cyc = 0;
    int t_wr = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    flash_mbox_ctrl #(.PROG_LAT(PROG), .ERASE_LAT(ERASE), .TAIL_LAT(TAIL)) u0 (
        .clk(clk), .rst(rst), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .remap_init(remap_init),
        .lock_bits(lock_bits), .ext_int1_n(ext_int1_n), .int1_n(int1_n),
        .upper_vis(upper_vis), .map_en(map_en)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
        @(negedge clk);
        sfr_we = 1'b0;
        t_wr = cyc;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        sfr_addr = a;
        #1;
        v = sfr_rdata;
    endtask

    task automatic set_addr(input logic [15:0] fa);
        wr(8'hB3, fa[7:0]);
        wr(8'hB4, fa[15:8]);
    endtask

    // Sample status each falling edge; record the cycles where BUSY and Flash_busy fall.
    task automatic measure(output int tb, output int tf);
        logic [7:0] s;
        tb = -1; tf = -1;
        for (int k = 0; k < 400; k++) begin
            rd(8'hB6, s);
            if (!s[1] && tb < 0) tb = cyc;
            if (!s[0]) begin tf = cyc; break; end
            @(negedge clk);
        end
    endtask

    task automatic verify(input logic [15:0] fa, output logic [7:0] v);
        int tb, tf, t0;
        set_addr(fa);
        wr(8'hB2, 8'h0C);
        t0 = t_wr;
        measure(tb, tf);
        chk("R7 verify latency", tf - t0, 1);
        rd(8'hB5, v);
    endtask

    task automatic prog(input logic [15:0] fa, input logic [7:0] d);
        int tb, tf, t0;
        set_addr(fa);
        wr(8'hB5, d);
        wr(8'hB2, 8'h0E);
        t0 = t_wr;
        measure(tb, tf);
        chk("R5 busy window", tb - t0, PROG);
        chk("R5 flash_busy window", tf - t0, PROG);
    endtask

    task automatic erase(input logic [15:0] fa, input logic [7:0] code);
        int tb, tf, t0;
        set_addr(fa);
        wr(8'hB2, code);
        t0 = t_wr;
        measure(tb, tf);
        chk("R6 erase latency", tf - t0, ERASE);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(8'hB2, v); chk("R1 cmd reset", v, 8'h00);
        rd(8'hB3, v); chk("R1 addr low reset", v, 8'h00);
        rd(8'hB4, v); chk("R1 addr high reset", v, 8'h00);
        rd(8'hB5, v); chk("R1 data reset", v, 8'h00);
        rd(8'hB1, v); chk("R1 cfg reset", v, 8'h02);
        rd(8'hB6, v); chk("R1 status reset", v, 8'hA0);
        chk("R11 map_en reset", map_en, 2'b10);
        ext_int1_n = 1'b0; #1; chk("R1 int passthrough", int1_n, 0);
        ext_int1_n = 1'b1; #1; chk("R1 int passthrough", int1_n, 1);
    endtask

    task automatic t_disabled_and_cfg();
        logic [7:0] v;
        set_addr(16'h0010);
        wr(8'hB5, 8'h00);
        wr(8'hB2, 8'h0E);
        rd(8'hB6, v); chk("R4 no start when disabled", v[0], 0);
        wr(8'hB1, 8'hFC);
        rd(8'hB1, v); chk("R11 cfg bits 5:2 read zero", v, 8'hC0);
        chk("R11 upper_vis set", upper_vis, 1);
        wr(8'hB1, 8'h40);
        chk("R11 upper_vis clear", upper_vis, 0);
        wr(8'hB6, 8'hFF);
        rd(8'hB6, v); chk("R2 status read-only", v, 8'hA0);
        verify(16'h0010, v); chk("R4 memory untouched", v, 8'hFF);
    endtask

    task automatic t_program();
        logic [7:0] v;
        prog(16'h0010, 8'hA5);
        verify(16'h0010, v); chk("R5 first program", v, 8'hA5);
        prog(16'h0010, 8'h3C);
        verify(16'h0010, v); chk("R5 program ANDs", v, 8'h24);
        verify(16'h2000, v); chk("R7 out of range reads FF", v, 8'hFF);
    endtask

    task automatic t_reserved();
        logic [7:0] v;
        set_addr(16'h0010);
        wr(8'hB2, 8'h05);
        rd(8'hB6, v); chk("R3 reserved code idle", v[0], 0);
        verify(16'h0010, v); chk("R3 reserved leaves memory", v, 8'h24);
    endtask

    task automatic t_busy_ignore();
        logic [7:0] v;
        int tb, tf, t0;
        set_addr(16'h0040);
        wr(8'hB5, 8'h00);
        wr(8'hB2, 8'h0E);
        t0 = t_wr;
        wr(8'hB2, 8'h01);
        measure(tb, tf);
        chk("R9 run not restarted", tf - t0, PROG);
        rd(8'hB2, v); chk("R9 cmd register kept", v, 8'h0E);
        verify(16'h0040, v); chk("R9 chip erase ignored", v, 8'h00);
    endtask

    task automatic t_erases();
        logic [7:0] v;
        prog(16'h0080, 8'h11);
        prog(16'h0100, 8'h22);
        prog(16'hF040, 8'h33);
        prog(16'hF080, 8'h44);
        erase(16'h00C3, 8'h0B);
        verify(16'h0080, v); chk("R6 main sector erased", v, 8'hFF);
        verify(16'h0100, v); chk("R6 next main sector kept", v, 8'h22);
        verify(16'h0040, v); chk("R6 prior main sector kept", v, 8'h00);
        erase(16'hF050, 8'h0B);
        verify(16'hF040, v); chk("R6 upper sector erased", v, 8'hFF);
        verify(16'hF080, v); chk("R6 next upper sector kept", v, 8'h44);
        erase(16'hF000, 8'h0D);
        verify(16'hF080, v); chk("R6 upper block erased", v, 8'hFF);
        verify(16'h0100, v); chk("R6 main kept on upper block erase", v, 8'h22);
        prog(16'hF001, 8'h55);
        erase(16'h0000, 8'h0D);
        verify(16'h0100, v); chk("R6 main block erased", v, 8'hFF);
        verify(16'hF001, v); chk("R6 upper kept on main block erase", v, 8'h55);
        prog(16'h0003, 8'h66);
        erase(16'h0000, 8'h01);
        verify(16'h0003, v); chk("R6 chip erase main", v, 8'hFF);
        verify(16'hF001, v); chk("R6 chip erase upper", v, 8'hFF);
    endtask

    task automatic t_burst();
        logic [7:0] v;
        int tb, tf, t0;
        set_addr(16'h0030);
        wr(8'hB5, 8'h5A);
        wr(8'hB2, 8'h06);
        t0 = t_wr;
        measure(tb, tf);
        chk("R8 first burst busy", tb - t0, PROG);
        chk("R8 first burst flash_busy", tf - t0, PROG + TAIL);
        set_addr(16'h0031);
        wr(8'hB5, 8'hC3);
        wr(8'hB2, 8'h06);
        t0 = t_wr;
        rd(8'hB6, v); chk("R8 burst in tail started", v[1:0], 2'b11);
        for (int k = 0; k < PROG; k++) @(negedge clk);
        rd(8'hB6, v); chk("R8 tail phase flags", v[1:0], 2'b01);
        wr(8'hB2, 8'h0C);
        measure(tb, tf);
        chk("R8 tail end after ignored cmd", tf - t0, PROG + TAIL);
        rd(8'hB5, v); chk("R8 verify in tail ignored", v, 8'hC3);
        verify(16'h0030, v); chk("R8 burst byte 0", v, 8'h5A);
        verify(16'h0031, v); chk("R8 burst byte 1", v, 8'hC3);
    endtask

    task automatic t_interrupt();
        logic [7:0] v;
        int tb, tf;
        set_addr(16'h0050);
        wr(8'hB5, 8'h0F);
        wr(8'hB2, 8'h8E);
        ext_int1_n = 1'b0; #1;
        chk("R10 external ignored while routed", int1_n, 1);
        measure(tb, tf);
        chk("R10 completion irq low", int1_n, 0);
        ext_int1_n = 1'b1; #1;
        chk("R10 irq held", int1_n, 0);
        wr(8'hB2, 8'h8C);
        chk("R10 irq cleared by cmd write", int1_n, 1);
        measure(tb, tf);
        chk("R7 verify raises no irq", int1_n, 1);
        wr(8'hB2, 8'h0E);
        measure(tb, tf);
        chk("R10 no irq without enable", int1_n, 1);
        ext_int1_n = 1'b0; #1;
        chk("R10 passthrough low", int1_n, 0);
        ext_int1_n = 1'b1; #1;
        chk("R10 passthrough high", int1_n, 1);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_disabled_and_cfg();
        t_program();
        t_reserved();
        t_busy_ignore();
        t_erases();
        t_burst();
        t_interrupt();
        summary();
    end

endmodule